// File: doc/BRIEF.md
# ADC Result Formatting FIFO

This block sits between a successive-approximation converter and a host bus. Each time the converter pulses its conversion-complete strobe, the block takes the 12-bit code and recodes it into a 16-bit word. The recoding follows a unipolar/bipolar mode input that is sampled with that write. The word is then stored in a 16-entry first-in first-out buffer. The host drains the buffer through a read strobe, and the word appears on a registered output one cycle later.

In unipolar mode the code is an unsigned count and gets four zero bits on top. In bipolar mode the top code bit is flipped, which turns offset binary into two's complement. The result is then sign-extended, so negative values carry an all-ones upper nibble.

A status output shows whether any word is waiting. If a conversion arrives while the buffer already holds 16 unread words, that sample is discarded and a sticky overflow flag is raised. The flag stays set until the host pulses the clear input, which also empties the buffer.

Top module: `adc_fmt_fifo`

## Requirements
- R1: With `bipolar` low at the write, the stored word is the 12-bit code in bits 11:0 with bits 15:12 all zero (value 0 to 4095).
- R2: With `bipolar` high at the write, bits 11:0 hold the code with bit 11 inverted. Bits 15:12 copy the new bit 11, so the 16-bit word equals code minus 2048 in two's complement (0x0000 for code 0x800, 0xF800 for code 0x000, 0x07FF for code 0xFFF).
- R3: The mode is taken in the cycle of each write. Changing `bipolar` later does not alter words already stored.
- R4: Words are read in write order. A read strobe with data present updates `rd_data` in the cycle after the strobe, and the buffer holds 16 words.
- R5: `data_avail` is high in the cycle after any write and stays high exactly while at least one word is stored.
- R6: A conversion strobe with 16 words stored and no read in the same cycle sets `ovf_err` in the next cycle. That sample is lost and the 16 stored words are kept unchanged.
- R7: `ovf_err` stays set until `clr` is pulsed. `clr` empties the buffer and clears the flag in the next cycle, and it overrides a write or read in the same cycle.
- R8: A read strobe on an empty buffer leaves `rd_data` unchanged and does not move the read position. Without a read strobe, `rd_data` also stays unchanged.
- R9: A write and a read in the same cycle on a full buffer are both accepted. `ovf_err` stays low and the buffer stays full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_done | input | 1 | Conversion-complete strobe, one write per cycle high |
| conv_code | input | 12 | Raw converter code |
| bipolar | input | 1 | Coding mode for this write: 1 bipolar, 0 unipolar |
| rd_en | input | 1 | Host read strobe |
| clr | input | 1 | Empty the buffer and clear the overflow flag |
| rd_data | output | 16 | Word read by the last accepted read |
| data_avail | output | 1 | At least one word is stored |
| ovf_err | output | 1 | Sticky overflow error |

## Verification
On every cycle the assertions check four things: that the upper nibble of the output is all zeros or all ones, that a write raises `data_avail`, that the overflow flag only rises after a write with no read, and that the flag holds until a clear. They also check that `rd_data` holds when no read is taken or the buffer is empty.

The exact recoding of every code in both modes is shown only by the bench's full sweep. The same holds for the storage order, the loss of the seventeenth sample with the older words kept intact, the late mode change and the simultaneous read and write on a full buffer.

// File: rtl/adc_fmt_fifo.sv
module adc_fmt_fifo #(
  parameter int CODE_W = 12,
  parameter int WORD_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [CODE_W-1:0] conv_code,
  input  logic              bipolar,
  input  logic              rd_en,
  input  logic              clr,
  output logic [WORD_W-1:0] rd_data,
  output logic              data_avail,
  output logic              ovf_err
);
  localparam int AW  = $clog2(DEPTH);
  localparam int CW  = AW + 1;
  localparam int EXT = WORD_W - CODE_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic [CW-1:0]     count;

  wire empty = (count == '0);
  wire full  = (count == CW'(DEPTH));
  wire rd_ok = rd_en && !empty && !clr;
  wire wr_ok = conv_done && (!full || rd_ok) && !clr;
  wire lose  = conv_done && full && !rd_ok && !clr;

  wire [CODE_W-1:0] coded = bipolar ? {~conv_code[CODE_W-1], conv_code[CODE_W-2:0]}
                                    : conv_code;
  wire              fill  = bipolar & coded[CODE_W-1];
  wire [WORD_W-1:0] word  = {{EXT{fill}}, coded};

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk)
    if (wr_ok) mem[wptr] <= word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      rd_data <= '0;
      ovf_err <= 1'b0;
    end else if (clr) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      ovf_err <= 1'b0;
    end else begin
      if (wr_ok) wptr <= bump(wptr);
      if (rd_ok) begin
        rptr    <= bump(rptr);
        rd_data <= mem[rptr];
      end
      if (wr_ok && !rd_ok)      count <= count + 1'b1;
      else if (rd_ok && !wr_ok) count <= count - 1'b1;
      if (lose) ovf_err <= 1'b1;
    end
  end

  assign data_avail = !empty;
endmodule

// File: rtl/adc_fmt_fifo_chk.sv
module adc_fmt_fifo_chk #(
  parameter int CODE_W = 12,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_done,
  input logic              rd_en,
  input logic              clr,
  input logic [WORD_W-1:0] rd_data,
  input logic              data_avail,
  input logic              ovf_err
);
  // R1 R2
  ext_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[WORD_W-1:CODE_W] == '0) || (rd_data[WORD_W-1:CODE_W] == '1));

  // R5
  wr_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && !clr |=> data_avail);

  // R7
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !data_avail && !ovf_err);

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err && !clr |=> ovf_err);

  // R6
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_err) |-> $past(conv_done && !rd_en && !clr && data_avail));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !data_avail |=> $stable(rd_data));
endmodule

bind adc_fmt_fifo adc_fmt_fifo_chk #(.CODE_W(CODE_W), .WORD_W(WORD_W)) chk (
  .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .rd_en(rd_en), .clr(clr),
  .rd_data(rd_data), .data_avail(data_avail), .ovf_err(ovf_err)
);

// File: tb/adc_fmt_fifo_test.sv
module adc_fmt_fifo_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_done = 1'b0;
  logic [11:0] conv_code = '0;
  logic        bipolar = 1'b0;
  logic        rd_en = 1'b0;
  logic        clr = 1'b0;
  logic [15:0] rd_data;
  logic        data_avail;
  logic        ovf_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  adc_fmt_fifo uut (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_code(conv_code),
    .bipolar(bipolar), .rd_en(rd_en), .clr(clr), .rd_data(rd_data),
    .data_avail(data_avail), .ovf_err(ovf_err)
  );

  function automatic logic [15:0] expect_word(input int code, input bit bip);
    int v;
    v = bip ? code - 2048 : code;
    return 16'(v);
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycle(input bit w, input int code, input bit bip, input bit r, input bit c);
    @(negedge clk);
    conv_done = w; conv_code = 12'(code); bipolar = bip; rd_en = r; clr = c;
    @(negedge clk);
    conv_done = 0; rd_en = 0; clr = 0;
  endtask

  task automatic push(input int code, input bit bip);
    cycle(1, code, bip, 0, 0);
  endtask

  task automatic pop();
    cycle(0, 0, 0, 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data == 0, "R5 reset rd_data", rd_data, 16'h0);
    check(data_avail == 0, "R5 reset avail", 16'(data_avail), 16'h0);
    check(ovf_err == 0, "R7 reset ovf", 16'(ovf_err), 16'h0);

    // R1 R2: every code in both modes
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 4096; c++) begin
        push(c, m[0]);
        pop();
        check(rd_data == expect_word(c, m[0]), m ? "R2 bipolar code" : "R1 unipolar code",
              rd_data, expect_word(c, m[0]));
      end
    check(data_avail == 0, "R5 drained", 16'(data_avail), 16'h0);

    // R3: mode taken at write; later change has no effect
    push(12'h123, 0);
    push(12'h123, 1);
    bipolar = 1;
    pop();
    check(rd_data == 16'h0123, "R3 first word", rd_data, 16'h0123);
    bipolar = 0;
    pop();
    check(rd_data == 16'hF923, "R3 second word", rd_data, 16'hF923);

    // R4 R6: fill, overflow, drain in order
    for (int i = 0; i < 16; i++) push(i * 200 + 7, 0);
    check(data_avail == 1, "R5 full avail", 16'(data_avail), 16'h1);
    check(ovf_err == 0, "R6 no ovf at 16", 16'(ovf_err), 16'h0);
    push(12'hABC, 0);
    check(ovf_err == 1, "R6 ovf set", 16'(ovf_err), 16'h1);
    for (int i = 0; i < 16; i++) begin
      pop();
      check(rd_data == 16'(i * 200 + 7), "R4 R6 order kept", rd_data, 16'(i * 200 + 7));
    end
    check(data_avail == 0, "R6 lost sample not stored", 16'(data_avail), 16'h0);
    // R8: empty read holds value
    pop();
    check(rd_data == 16'(15 * 200 + 7), "R8 empty read", rd_data, 16'(15 * 200 + 7));
    push(12'h055, 0);
    pop();
    check(rd_data == 16'h0055, "R8 pointer unmoved", rd_data, 16'h0055);
    check(ovf_err == 1, "R7 sticky", 16'(ovf_err), 16'h1);
    cycle(0, 0, 0, 0, 1);
    check(ovf_err == 0, "R7 clr flag", 16'(ovf_err), 16'h0);

    // R9: simultaneous write and read on full
    for (int i = 0; i < 16; i++) push(i + 100, 0);
    cycle(1, 12'h3E8, 0, 1, 0);
    check(rd_data == 16'd100, "R9 read on full", rd_data, 16'd100);
    check(ovf_err == 0, "R9 no ovf", 16'(ovf_err), 16'h0);
    push(12'h001, 0);
    check(ovf_err == 1, "R9 still full", 16'(ovf_err), 16'h1);
    for (int i = 1; i < 16; i++) begin
      pop();
      check(rd_data == 16'(i + 100), "R9 order", rd_data, 16'(i + 100));
    end
    pop();
    check(rd_data == 16'h03E8, "R9 new word last", rd_data, 16'h03E8);

    // R7: clr empties and beats a same-cycle write
    push(12'h011, 0);
    push(12'h022, 0);
    cycle(1, 12'h033, 0, 1, 1);
    check(data_avail == 0, "R7 clr empties", 16'(data_avail), 16'h0);
    check(ovf_err == 0, "R7 clr clears", 16'(ovf_err), 16'h0);
    check(rd_data == 16'h03E8, "R7 clr beats read", rd_data, 16'h03E8);
    push(12'h044, 1);
    pop();
    check(rd_data == 16'hF844, "R7 R2 after clr", rd_data, 16'hF844);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule